// File: doc/BRIEF.md
# Serial Link Lock Monitor

This block watches a recovered serial bit stream, one bit per clock when a valid strobe is high, and judges from the data's own statistics whether the receive clock recovery is still locked. Two rules apply: the longest run of identical bits must stay within a limit, and each fixed window of bits must hold a minimum number of bit-to-bit transitions. A broken rule drops the lock flag and steers the downstream clock select to the local reference, so the downstream logic keeps a clock of the right frequency.

After reset or after any loss of lock, the block stays in a reference-acquisition state for a programmable number of clocks before it tries the data again. The interval completes either while an external request holds the block in acquisition, or while the line shows no valid transitions. Once out of acquisition the block measures one full window; if that window is clean, the lock flag rises.

Top module: `link_lock_monitor`

## Requirements
- R1: While rst_ni is low, and right after it goes low, locked_o is 0 and ref_sel_o is 1 (acquisition state).
- R2: In acquisition with ref_lock_req_i low and no valid transitions, ref_sel_o falls on the ACQ_CYCLES+1-th rising edge after the edge that entered acquisition (or after reset release), and not earlier.
- R3: In acquisition, a valid bit that differs from the previous valid bit while ref_lock_req_i is low restarts the acquisition interval.
- R4: ref_lock_req_i high at a rising edge puts the block in acquisition (ref_sel_o 1, locked_o 0) from any state; while held, the interval counts regardless of data, and after a full interval has elapsed the block leaves acquisition at the first edge with the request low.
- R5: Outside acquisition ref_sel_o is 0. Windows of WIN_LEN (256) valid bits start at the exit from acquisition; locked_o rises at the edge that takes the last bit of a window with no violation, and stays 0 before it.
- R6: A valid bit that makes a run of more than RUN_MAX (64) identical consecutive valid bits causes loss of lock at that edge; a run of exactly 64 does not. Run counting restarts at the exit from acquisition.
- R7: A transition is a valid bit that differs from the previous valid bit (the previous bit is 0 after reset). A window ending with fewer than MIN_TRANS (31) transitions causes loss of lock at its last bit; exactly 31 does not.
- R8: A repeated bit in an alternating stream (a phase step) and gaps in the valid strobe do not cause loss of lock.
- R9: bit_i has no effect while bit_valid_i is low: it does not restart acquisition, extend a run or count towards a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Recovered data bit |
| bit_valid_i | input | 1 | bit_i carries a new bit this cycle |
| ref_lock_req_i | input | 1 | Force reference acquisition while high |
| locked_o | output | 1 | Recovery judged locked to data |
| ref_sel_o | output | 1 | 1: downstream clock from local reference; 0: from recovered timing |

## Verification
The assertions assume that bit_i only matters when bit_valid_i is high and that ref_lock_req_i is a level sampled on the clock, so any request seen at an edge must leave the block in acquisition one cycle later. They also take for granted that a loss-of-lock pulse from either rule is acted upon at the very next edge, with no request needed. The stimulus drives every input at the falling edge, keeps each run at or below 16 bits except the deliberate 64 and 65 bit runs, and toggles bit_i during invalid cycles only to show that those bits are discarded.

// File: rtl/lock_mon_pkg.sv
package lock_mon_pkg;
  typedef enum logic [1:0] {
    ST_ACQ    = 2'd0,
    ST_TRAIN  = 2'd1,
    ST_LOCKED = 2'd2
  } lock_state_e;
endpackage

// File: rtl/lock_run_tracker.sv
module lock_run_tracker #(
  parameter int RUN_MAX = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic bit_i,
  input  logic valid_i,
  output logic toggle_o,
  output logic run_viol_o
);
  localparam int RW = $clog2(RUN_MAX + 1);

  logic          prev_q;
  logic [RW-1:0] run_q;
  logic          same;

  assign same       = (bit_i == prev_q);
  assign toggle_o   = valid_i && !same;
  assign run_viol_o = valid_i && same && !clear_i && (run_q == RW'(RUN_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      run_q  <= '0;
    end else begin
      if (valid_i) prev_q <= bit_i;
      if (clear_i) begin
        run_q <= '0;
      end else if (valid_i) begin
        if (!same)                      run_q <= RW'(1);
        else if (run_q != RW'(RUN_MAX)) run_q <= run_q + RW'(1);
      end
    end
  end

  // run counter saturates at the limit; violation flags the overflowing bit
  a_r6_run_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RW'(RUN_MAX));
endmodule

// File: rtl/lock_density_window.sv
module lock_density_window #(
  parameter int WIN_LEN   = 256,
  parameter int MIN_TRANS = 31
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic valid_i,
  input  logic toggle_i,
  output logic win_done_o,
  output logic dens_viol_o
);
  localparam int WW = $clog2(WIN_LEN);
  localparam int TW = $clog2(WIN_LEN + 1);

  logic [WW-1:0] win_q;
  logic [TW-1:0] trans_q;
  logic [TW-1:0] trans_tot;
  logic          win_last;

  assign win_last    = (win_q == WW'(WIN_LEN - 1));
  assign trans_tot   = trans_q + TW'(toggle_i);
  assign win_done_o  = valid_i && !clear_i && win_last;
  assign dens_viol_o = win_done_o && (trans_tot < TW'(MIN_TRANS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      trans_q <= '0;
    end else if (clear_i) begin
      win_q   <= '0;
      trans_q <= '0;
    end else if (valid_i) begin
      if (win_last) begin
        win_q   <= '0;
        trans_q <= '0;
      end else begin
        win_q   <= win_q + WW'(1);
        trans_q <= trans_tot;
      end
    end
  end

  // transitions in a window cannot outnumber the bits seen in it
  a_r7_trans_le_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trans_q <= TW'(win_q));
endmodule

// File: rtl/lock_acq_timer.sv
module lock_acq_timer #(
  parameter int ACQ_CYCLES = 1250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic hold_i,
  input  logic activity_i,
  output logic done_o
);
  localparam int AW = $clog2(ACQ_CYCLES + 1);

  logic [AW-1:0] cnt_q;

  assign done_o = (cnt_q == AW'(ACQ_CYCLES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!active_i)           cnt_q <= '0;
    else if (activity_i && !hold_i) cnt_q <= '0;  // data seen: not a quiet interval
    else if (!done_o)             cnt_q <= cnt_q + AW'(1);
  end

  a_r3_timer_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= AW'(ACQ_CYCLES));
endmodule

// File: rtl/link_lock_monitor.sv
module link_lock_monitor
  import lock_mon_pkg::*;
#(
  parameter int RUN_MAX    = 64,
  parameter int WIN_LEN    = 256,
  parameter int MIN_TRANS  = 31,
  parameter int ACQ_CYCLES = 1250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic bit_valid_i,
  input  logic ref_lock_req_i,
  output logic locked_o,
  output logic ref_sel_o
);
  lock_state_e state_q, state_d;
  logic in_acq;
  logic toggle, run_viol, win_done, dens_viol, acq_done;

  assign in_acq = (state_q == ST_ACQ);

  lock_run_tracker #(.RUN_MAX(RUN_MAX)) u_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (in_acq),
    .bit_i      (bit_i),
    .valid_i    (bit_valid_i),
    .toggle_o   (toggle),
    .run_viol_o (run_viol)
  );

  lock_density_window #(.WIN_LEN(WIN_LEN), .MIN_TRANS(MIN_TRANS)) u_dens (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (in_acq),
    .valid_i     (bit_valid_i),
    .toggle_i    (toggle),
    .win_done_o  (win_done),
    .dens_viol_o (dens_viol)
  );

  lock_acq_timer #(.ACQ_CYCLES(ACQ_CYCLES)) u_acq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (in_acq),
    .hold_i     (ref_lock_req_i),
    .activity_i (toggle),
    .done_o     (acq_done)
  );

  always_comb begin
    state_d = state_q;
    if (ref_lock_req_i) begin
      state_d = ST_ACQ;
    end else begin
      unique case (state_q)
        ST_ACQ:    if (acq_done) state_d = ST_TRAIN;
        ST_TRAIN:  if (run_viol || dens_viol) state_d = ST_ACQ;
                   else if (win_done)         state_d = ST_LOCKED;
        ST_LOCKED: if (run_viol || dens_viol) state_d = ST_ACQ;
        default:   state_d = ST_ACQ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ACQ;
    else         state_q <= state_d;
  end

  assign locked_o  = (state_q == ST_LOCKED);
  assign ref_sel_o = in_acq;

  a_r2_exit_after_interval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ref_sel_o) |-> $past(acq_done));
  a_r4_req_forces_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_lock_req_i |=> (ref_sel_o && !locked_o));
  a_r5_lock_on_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(win_done));
  a_r6_run_drops_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_viol |=> ref_sel_o);
  a_r7_density_drops_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dens_viol |=> ref_sel_o);
endmodule

// File: tb/link_lock_monitor_bench.sv
`timescale 1ns/1ps
module link_lock_monitor_bench;
  localparam int A = 40;  // shortened acquisition interval

  localparam logic [2:0] OP_IDLE  = 3'd0;  // valid low, bit_i toggling
  localparam logic [2:0] OP_ALT   = 3'd1;  // alternating valid bits from val
  localparam logic [2:0] OP_CONST = 3'd2;  // constant valid bits of val
  localparam logic [2:0] OP_RUNS  = 3'd3;  // num runs of len bits, first run = val
  localparam logic [2:0] OP_HOLD  = 3'd4;  // request high, alternating bits

  typedef struct packed {
    logic [2:0]  op;
    logic        val;
    logic [15:0] len;
    logic [15:0] num;
    logic        exp_lock;
    logic        exp_ref;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{OP_IDLE,  1'b0, 16'd0, 16'(A),    1'b0, 1'b1, "R2 "},  // interval not done; R9 toggles ignored
    '{OP_IDLE,  1'b0, 16'd0, 16'd1,     1'b0, 1'b0, "R2 "},  // quiet interval done
    '{OP_ALT,   1'b1, 16'd0, 16'd255,   1'b0, 1'b0, "R5 "},  // window incomplete
    '{OP_CONST, 1'b0, 16'd0, 16'd1,     1'b1, 1'b0, "R5 "},  // clean window -> lock
    '{OP_CONST, 1'b0, 16'd0, 16'd63,    1'b1, 1'b0, "R6 "},  // run of 64 tolerated
    '{OP_CONST, 1'b0, 16'd0, 16'd1,     1'b0, 1'b1, "R6 "},  // run of 65 -> loss
    '{OP_ALT,   1'b1, 16'd0, 16'(A+10), 1'b0, 1'b1, "R3 "},  // activity restarts interval
    '{OP_HOLD,  1'b1, 16'd0, 16'(A+5),  1'b0, 1'b1, "R4 "},  // held in acquisition
    '{OP_IDLE,  1'b0, 16'd0, 16'd1,     1'b0, 1'b0, "R4 "},  // exit on release
    '{OP_RUNS,  1'b1, 16'd8, 16'd30,    1'b0, 1'b0, "R7 "},  // 29 transitions
    '{OP_CONST, 1'b1, 16'd0, 16'd15,    1'b0, 1'b0, "R7 "},  // 30 transitions, 255 bits
    '{OP_CONST, 1'b1, 16'd0, 16'd1,     1'b0, 1'b1, "R7 "},  // 30 < 31 -> loss
    '{OP_IDLE,  1'b0, 16'd0, 16'(A+1),  1'b0, 1'b0, "R2 "},  // reacquired
    '{OP_RUNS,  1'b1, 16'd8, 16'd31,    1'b0, 1'b0, "R7 "},  // 30 transitions
    '{OP_CONST, 1'b0, 16'd0, 16'd7,     1'b0, 1'b0, "R7 "},  // 31 transitions, 255 bits
    '{OP_CONST, 1'b0, 16'd0, 16'd1,     1'b1, 1'b0, "R7 "},  // exactly 31 -> lock
    '{OP_ALT,   1'b1, 16'd0, 16'd100,   1'b1, 1'b0, "R8 "},
    '{OP_CONST, 1'b0, 16'd0, 16'd1,     1'b1, 1'b0, "R8 "},  // repeated bit (phase step)
    '{OP_IDLE,  1'b0, 16'd0, 16'd5,     1'b1, 1'b0, "R9 "},  // gap, bit_i toggles unseen
    '{OP_ALT,   1'b1, 16'd0, 16'd200,   1'b1, 1'b0, "R8 "},  // crosses window boundary
    '{OP_HOLD,  1'b1, 16'd0, 16'd1,     1'b0, 1'b1, "R4 "},  // request drops lock
    '{OP_IDLE,  1'b0, 16'd0, 16'(A),    1'b0, 1'b1, "R9 "},  // invalid toggles no restart
    '{OP_IDLE,  1'b0, 16'd0, 16'd1,     1'b0, 1'b0, "R9 "}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_i = 1'b0;
  logic bit_valid_i = 1'b0;
  logic ref_lock_req_i = 1'b0;
  logic locked_o, ref_sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  link_lock_monitor #(
    .RUN_MAX(64), .WIN_LEN(256), .MIN_TRANS(31), .ACQ_CYCLES(A)
  ) u_link_lock_monitor (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .bit_i          (bit_i),
    .bit_valid_i    (bit_valid_i),
    .ref_lock_req_i (ref_lock_req_i),
    .locked_o       (locked_o),
    .ref_sel_o      (ref_sel_o)
  );

  task automatic check(input logic lk, input logic rs, input string tag);
    checks++;
    if (locked_o !== lk || ref_sel_o !== rs) begin
      errors++;
      $display("FAIL %s: locked_o=%b ref_sel_o=%b expected locked_o=%b ref_sel_o=%b at %0t",
               tag, locked_o, ref_sel_o, lk, rs, $time);
    end
  endtask

  task automatic drive(input logic b, input logic v, input logic rq);
    bit_i = b; bit_valid_i = v; ref_lock_req_i = rq;
    @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    case (v.op)
      OP_IDLE:  for (int i = 0; i < int'(v.num); i++) drive(~bit_i, 1'b0, 1'b0);
      OP_ALT:   for (int i = 0; i < int'(v.num); i++) drive(v.val ^ i[0], 1'b1, 1'b0);
      OP_CONST: for (int i = 0; i < int'(v.num); i++) drive(v.val, 1'b1, 1'b0);
      OP_RUNS:  for (int r = 0; r < int'(v.num); r++)
                  for (int k = 0; k < int'(v.len); k++) drive(v.val ^ r[0], 1'b1, 1'b0);
      OP_HOLD:  for (int i = 0; i < int'(v.num); i++) drive(v.val ^ i[0], 1'b1, 1'b1);
      default:  ;
    endcase
    bit_valid_i = 1'b0;
    ref_lock_req_i = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(1'b0, 1'b1, "R1 in reset");
    rst_ni = 1'b1;
    check(1'b0, 1'b1, "R1 after release");
    for (int n = 0; n < NV; n++) begin
      run_vec(VECS[n]);
      check(VECS[n].exp_lock, VECS[n].exp_ref, $sformatf("%s row %0d", VECS[n].tag, n));
    end
    // R5: training in progress, recovered timing selected, no lock yet
    for (int i = 0; i < 10; i++) drive(i[0], 1'b1, 1'b0);
    bit_valid_i = 1'b0;
    check(1'b0, 1'b0, "R5 training");
    // R1: asynchronous reset mid-stream
    #2 rst_ni = 1'b0;
    #1 check(1'b0, 1'b1, "R1 async reset");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(1'b0, 1'b1, "R1 held after reset");
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule